// File: doc/BRIEF.md
# Branch Target and Link Unit

This unit resolves control transfers for a 16-bit compressed instruction stream. For each instruction halfword it gets, it produces the next program counter, an optional new link register value, the execution-mode bit and a pipeline-flush request. It handles four kinds of instruction:

- a register-indirect branch that can switch mode;
- a short conditional branch;
- an unconditional branch;
- a call split over two halfwords. The first halfword leaves a partial target in the link register, and the second halfword completes the jump and writes the return address.

The program counter input is the pipelined value, which is already ahead of the instruction. A separate stage evaluates the branch condition and delivers it as a single pass bit. All results are registered and appear one cycle after the instruction is presented.

Top module: `brlink_unit`

## Requirements
- R1: Every cycle with `in_valid` high gives exactly one cycle with `out_valid` high on the next cycle. `flush`, `link_we` and `undef` are low in any cycle where `out_valid` is low.
- R2: When `instr[15:8]` = 0x47 and `instr[7]` = 0, the unit performs an indirect branch. `pc_out` is `reg_val` with bit 0 cleared, `mode_out` takes `reg_val[0]` (1 = compressed mode), and `flush` is 1.
- R3: When `instr[15:8]` = 0x47 and `instr[7]` = 1, the encoding is undefined. `undef` is 1, `pc_out` equals `pc_in`, `flush` and `link_we` are 0, and `mode_out` keeps its previous value.
- R4: When `instr[15:12]` = 0xD, `instr[11:8]` is not 0xF and `cond_pass` = 1, `pc_out` = `pc_in` + (sign-extended `instr[7:0]` << 1) and `flush` is 1.
- R5: The same encoding as R4 with `cond_pass` = 0 gives `pc_out` = `pc_in` and `flush` = 0.
- R6: When `instr[15:11]` = 11100b, `pc_out` = `pc_in` + (sign-extended `instr[10:0]` << 1) and `flush` is 1.
- R7: When `instr[15:11]` = 11110b, `link_out` = `pc_in` + (sign-extended `instr[10:0]` << 12) and `link_we` is 1. `pc_out` equals `pc_in` and `flush` is 0.
- R8: When `instr[15:11]` = 11111b, `pc_out` = `link_in` + (zero-extended `instr[10:0]` << 1), `link_out` = (`pc_in` − 2) with bit 0 set, and both `link_we` and `flush` are 1.
- R9: Any other halfword, including `instr[15:8]` = 0xDF, gives `pc_out` = `pc_in` with `flush`, `link_we` and `undef` all 0.
- R10: After reset, `out_valid`, `flush`, `link_we`, `undef`, `pc_out` and `link_out` are 0, and `mode_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr | input | 16 | Instruction halfword |
| pc_in | input | 32 | Pipelined program counter |
| link_in | input | 32 | Current link register value |
| reg_val | input | 32 | Register operand of the indirect branch |
| cond_pass | input | 1 | Condition of the conditional branch holds |
| out_valid | output | 1 | Results valid |
| pc_out | output | 32 | Next program counter |
| link_out | output | 32 | New link register value |
| link_we | output | 1 | Write `link_out` to the link register |
| mode_out | output | 1 | Execution mode, 1 = compressed |
| flush | output | 1 | Pipeline flush request |
| undef | output | 1 | Undefined-instruction indication |

## Verification
The bench uses the most negative and most positive offsets of each branch. A design that zero-extended the short offsets would jump forward instead of back, and one that shifted by the wrong amount would land at the wrong half or word address. For the second call halfword, an all-ones field must add +0xFFE. A design that sign-extended that field would step back by 2, and one that forgot to set bit 0 of the return link would fail the link compare. The bench also covers the undefined indirect form, a mode switch into and out of the compressed mode, a not-taken branch that must not flush, a condition field of 0xF that must act as a non-branch, and back-to-back instructions that test the one-cycle latency.

// File: rtl/brlink_pkg.sv
package brlink_pkg;
  localparam int HW_W = 16;

  typedef enum logic [2:0] {
    K_NONE,
    K_XCHG,
    K_UNDEF,
    K_COND,
    K_JUMP,
    K_LONG1,
    K_LONG2
  } kind_e;
endpackage

// File: rtl/brlink_decode.sv
module brlink_decode
  import brlink_pkg::*;
(
  input  logic [HW_W-1:0] instr,
  output kind_e           kind
);
  localparam logic [7:0] XCHG_OPC  = 8'h47;
  localparam logic [3:0] COND_OPC  = 4'hD;
  localparam logic [3:0] COND_NONE = 4'hF;
  localparam logic [4:0] JUMP_OPC  = 5'b11100;
  localparam logic [4:0] LONG1_OPC = 5'b11110;
  localparam logic [4:0] LONG2_OPC = 5'b11111;

  always_comb begin
    kind = K_NONE;
    if (instr[15:8] == XCHG_OPC)
      kind = instr[7] ? K_UNDEF : K_XCHG;
    else if (instr[15:12] == COND_OPC && instr[11:8] != COND_NONE)
      kind = K_COND;
    else if (instr[15:11] == JUMP_OPC)
      kind = K_JUMP;
    else if (instr[15:11] == LONG1_OPC)
      kind = K_LONG1;
    else if (instr[15:11] == LONG2_OPC)
      kind = K_LONG2;
  end
endmodule

// File: rtl/brlink_target.sv
module brlink_target
  import brlink_pkg::*;
#(
  parameter int AW         = 32,
  parameter int SHORT_W    = 8,
  parameter int LONG_W     = 11,
  parameter int HI_SHIFT   = 12
) (
  input  kind_e           kind,
  input  logic [HW_W-1:0] instr,
  input  logic [AW-1:0]   pc_in,
  input  logic [AW-1:0]   link_in,
  input  logic [AW-1:0]   reg_val,
  input  logic            cond_pass,
  output logic [AW-1:0]   nxt_pc,
  output logic [AW-1:0]   nxt_link,
  output logic            nxt_link_we,
  output logic            nxt_flush,
  output logic            nxt_undef,
  output logic            nxt_mode_we,
  output logic            nxt_mode
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [AW-1:0] TWO = ONE << 1;

  logic [AW-1:0] short_off, jump_off, hi_off, lo_off;

  always_comb begin
    short_off = {{(AW-SHORT_W){instr[SHORT_W-1]}}, instr[SHORT_W-1:0]} << 1;
    jump_off  = {{(AW-LONG_W){instr[LONG_W-1]}}, instr[LONG_W-1:0]} << 1;
    hi_off    = {{(AW-LONG_W){instr[LONG_W-1]}}, instr[LONG_W-1:0]} << HI_SHIFT;
    lo_off    = {{(AW-LONG_W){1'b0}}, instr[LONG_W-1:0]} << 1;
  end

  always_comb begin
    nxt_pc      = pc_in;
    nxt_link    = link_in;
    nxt_link_we = 1'b0;
    nxt_flush   = 1'b0;
    nxt_undef   = 1'b0;
    nxt_mode_we = 1'b0;
    nxt_mode    = reg_val[0];
    case (kind)
      K_XCHG: begin
        nxt_pc      = reg_val & ~ONE;
        nxt_mode_we = 1'b1;
        nxt_flush   = 1'b1;
      end
      K_UNDEF: nxt_undef = 1'b1;
      K_COND: if (cond_pass) begin
        nxt_pc    = pc_in + short_off;
        nxt_flush = 1'b1;
      end
      K_JUMP: begin
        nxt_pc    = pc_in + jump_off;
        nxt_flush = 1'b1;
      end
      K_LONG1: begin
        nxt_link    = pc_in + hi_off;
        nxt_link_we = 1'b1;
      end
      K_LONG2: begin
        nxt_pc      = link_in + lo_off;
        nxt_link    = (pc_in - TWO) | ONE;
        nxt_link_we = 1'b1;
        nxt_flush   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/brlink_unit.sv
module brlink_unit
  import brlink_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [HW_W-1:0] instr,
  input  logic [AW-1:0]   pc_in,
  input  logic [AW-1:0]   link_in,
  input  logic [AW-1:0]   reg_val,
  input  logic            cond_pass,
  output logic            out_valid,
  output logic [AW-1:0]   pc_out,
  output logic [AW-1:0]   link_out,
  output logic            link_we,
  output logic            mode_out,
  output logic            flush,
  output logic            undef
);
  kind_e         kind;
  logic [AW-1:0] n_pc, n_link;
  logic          n_lwe, n_flush, n_undef, n_mwe, n_mode;

  brlink_decode u_dec (.instr(instr), .kind(kind));

  brlink_target #(.AW(AW)) u_tgt (
    .kind(kind), .instr(instr), .pc_in(pc_in), .link_in(link_in),
    .reg_val(reg_val), .cond_pass(cond_pass),
    .nxt_pc(n_pc), .nxt_link(n_link), .nxt_link_we(n_lwe),
    .nxt_flush(n_flush), .nxt_undef(n_undef),
    .nxt_mode_we(n_mwe), .nxt_mode(n_mode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      pc_out    <= '0;
      link_out  <= '0;
      link_we   <= 1'b0;
      mode_out  <= 1'b1;
      flush     <= 1'b0;
      undef     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      link_we   <= in_valid & n_lwe;
      flush     <= in_valid & n_flush;
      undef     <= in_valid & n_undef;
      if (in_valid) begin
        pc_out <= n_pc;
        if (n_lwe) link_out <= n_link;
        if (n_mwe) mode_out <= n_mode;
      end
    end
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_strobes_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (flush || link_we || undef) |-> out_valid);
  assert_xchg_target_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[15:8] == 8'h47 && !instr[7]) |=>
      (pc_out[0] == 1'b0 && mode_out == $past(reg_val[0]) && flush));
  assert_undef_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[15:8] == 8'h47 && instr[7]) |=>
      (undef && !flush && !link_we && pc_out == $past(pc_in) && $stable(mode_out)));
  assert_not_taken_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[15:12] == 4'hD && !cond_pass) |=> !flush);
  assert_first_half_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[15:11] == 5'b11110) |=> (link_we && !flush));
  assert_second_half_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[15:11] == 5'b11111) |=> (link_we && flush && link_out[0]));
endmodule

// File: tb/brlink_unit_tb_top.sv
module brlink_unit_tb_top;
  localparam int AW = 32;

  typedef struct {
    string       req;
    int          due;
    logic [31:0] pc;
    logic [31:0] link;
    logic        lwe;
    logic        mode;
    logic        flush;
    logic        undef;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] instr = '0;
  logic [31:0] pc_in = '0, link_in = '0, reg_val = '0;
  logic        cond_pass = 1'b0;
  logic        out_valid, link_we, mode_out, flush, undef;
  logic [31:0] pc_out, link_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit idle_bad = 0;
  logic m_mode = 1'b1;
  exp_t q[$];

  brlink_unit #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .pc_in(pc_in), .link_in(link_in), .reg_val(reg_val), .cond_pass(cond_pass),
    .out_valid(out_valid), .pc_out(pc_out), .link_out(link_out),
    .link_we(link_we), .mode_out(mode_out), .flush(flush), .undef(undef)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  // Driver: apply one instruction and push the expected result
  task automatic drive(input string req, input logic [15:0] ins, input logic [31:0] pc,
                       input logic [31:0] lr, input logic [31:0] rv, input logic cp,
                       input int gap);
    exp_t e;
    logic [31:0] s8, s11, z11;
    s8  = {{24{ins[7]}}, ins[7:0]};
    s11 = {{21{ins[10]}}, ins[10:0]};
    z11 = {21'd0, ins[10:0]};
    e.req = req; e.pc = pc; e.link = 32'h0; e.lwe = 0; e.flush = 0; e.undef = 0;
    if (ins[15:8] == 8'h47 && !ins[7]) begin
      e.pc = rv & 32'hFFFF_FFFE; m_mode = rv[0]; e.flush = 1;
    end else if (ins[15:8] == 8'h47) begin
      e.undef = 1;
    end else if (ins[15:12] == 4'hD && ins[11:8] != 4'hF) begin
      if (cp) begin e.pc = pc + (s8 << 1); e.flush = 1; end
    end else if (ins[15:11] == 5'b11100) begin
      e.pc = pc + (s11 << 1); e.flush = 1;
    end else if (ins[15:11] == 5'b11110) begin
      e.link = pc + (s11 << 12); e.lwe = 1;
    end else if (ins[15:11] == 5'b11111) begin
      e.pc = lr + (z11 << 1); e.link = (pc - 32'd2) | 32'd1; e.lwe = 1; e.flush = 1;
    end
    e.mode = m_mode;
    @(negedge clk);
    instr = ins; pc_in = pc; link_in = lr; reg_val = rv; cond_pass = cp; in_valid = 1'b1;
    e.due = cyc + 1;
    q.push_back(e);
    if (gap > 0) begin
      @(negedge clk);
      in_valid = 1'b0;
      instr = 16'hFFFF;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  // Monitor: compare results against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL R1: out_valid with nothing expected, actual=1 expected=0");
        end else begin
          exp_t e;
          e = q.pop_front();
          if (cyc != e.due || pc_out != e.pc || flush != e.flush || undef != e.undef ||
              link_we != e.lwe || mode_out != e.mode || (e.lwe && link_out != e.link)) begin
            errors++;
            $display("FAIL %s: actual cyc=%0d pc=%h link=%h lwe=%b mode=%b flush=%b undef=%b expected cyc=%0d pc=%h link=%h lwe=%b mode=%b flush=%b undef=%b",
                     e.req, cyc, pc_out, link_out, link_we, mode_out, flush, undef,
                     e.due, e.pc, e.link, e.lwe, e.mode, e.flush, e.undef);
          end
        end
      end else if (flush || link_we || undef) idle_bad = 1;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid || flush || link_we || undef || pc_out != 0 || link_out != 0 || mode_out != 1'b1) begin
      errors++;
      $display("FAIL R10: reset state actual v=%b f=%b lw=%b u=%b pc=%h lk=%h m=%b expected 0 0 0 0 0 0 1",
               out_valid, flush, link_we, undef, pc_out, link_out, mode_out);
    end
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    drive("R2", 16'h4740, 32'h100, 32'h0, 32'h0000_1235, 1'b0, 2); // stays compressed
    drive("R2", 16'h4708, 32'h104, 32'h0, 32'h0800_0100, 1'b0, 2); // leaves compressed mode
    drive("R3", 16'h4780, 32'h200, 32'h0, 32'h0000_0001, 1'b0, 2); // undefined, mode held at 0
    drive("R2", 16'h4778, 32'h204, 32'h0, 32'h0000_0AAB, 1'b0, 1); // back into compressed
    drive("R4", 16'hD0FE, 32'h1000, 32'h0, 32'h0, 1'b1, 0);        // back-to-back, -4
    drive("R4", 16'hD37F, 32'h1000, 32'h0, 32'h0, 1'b1, 0);        // +0xFE
    drive("R4", 16'hD880, 32'h1000, 32'h0, 32'h0, 1'b1, 1);        // -0x100
    drive("R5", 16'hD110, 32'h1000, 32'h0, 32'h0, 1'b0, 2);
    drive("R6", 16'hE3FF, 32'h2000, 32'h0, 32'h0, 1'b0, 1);        // +0x7FE
    drive("R6", 16'hE400, 32'h2000, 32'h0, 32'h0, 1'b0, 1);        // -0x800
    drive("R7", 16'hF7FF, 32'h3000, 32'h0, 32'h0, 1'b0, 0);
    drive("R8", 16'hFFFF, 32'h3002, 32'h0040_2000, 32'h0, 1'b0, 1);
    drive("R7", 16'hF400, 32'h0080_0000, 32'h0, 32'h0, 1'b0, 1);
    drive("R8", 16'hF800, 32'h0000_0010, 32'h1234_0000, 32'h0, 1'b0, 1);
    drive("R9", 16'hDF12, 32'h500, 32'h0, 32'h0, 1'b1, 1);         // condition field 0xF
    drive("R9", 16'h1234, 32'h504, 32'h77, 32'h3, 1'b1, 3);

    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0 || idle_bad) begin
      errors++;
      $display("FAIL R1: pending=%0d idle_strobe=%0b expected pending=0 idle_strobe=0", q.size(), idle_bad);
    end
    finish_run();
  end
endmodule